// File: doc/BRIEF.md
# Power-Fail Shadow Store and Recall Controller

This block manages a byte-wide working memory that has a nonvolatile shadow copy of the same depth. It watches two supply comparator flags. The first, `sup_ok`, says the supply is above the switch threshold. The second, `sup_low`, says the supply has fallen below the reset threshold. When the supply fails it copies the working bytes into the shadow. When the supply returns after a deep dip it copies the shadow back into the working bytes.

Host access goes through a single synchronous port that handles one read or one write per cycle. A write the block cannot take is dropped, and the block reports it with a one-cycle reject pulse. A read it cannot take produces no valid strobe. A software request can start the same shadow-to-working copy at any idle moment.

Every transfer moves one byte per clock over all addresses, then pads out to a fixed cycle count set by a parameter. `busy` covers the whole transfer and `done` marks its end. The shadow array has no reset. The working array is undefined until the first recall finishes.

Top module: `nvshadow_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `dirty`, `host_rvalid` and `host_wrej` are 0. A recall is already pending, so it starts on the first clock at which `sup_ok` is 1 (busy is seen one cycle after `sup_ok` rises).
- R2: A write is accepted when `host_req`=1, `host_we`=1, `sup_ok`=1, the block is idle and no recall starts in that cycle. The byte is stored and `dirty` reads 1 on the next cycle. A read (`host_req`=1, `host_we`=0) while not busy returns the stored byte with `host_rvalid`=1 one cycle later.
- R3: A write attempted while `sup_ok`=0 or while the block is not idle is dropped. The block pulses `host_wrej` for one cycle on the next clock. Memory contents and `dirty` are left unchanged.
- R4: A falling edge of `sup_ok` seen while idle with `dirty`=1 starts a store. `busy` stays low for `GRACE_CYC` cycles and then is high for exactly `STORE_CYC` cycles. Afterwards the shadow holds the working contents.
- R5: A falling edge of `sup_ok` with `dirty`=0 starts no store: `busy` and `done` stay 0.
- R6: `sup_low`=1 in any cycle latches a recall request. The recall starts once the block is idle with `sup_ok`=1. It keeps `busy` high for exactly `RESTORE_CYC` cycles and leaves the working array equal to the shadow.
- R7: A dip of `sup_ok` with `sup_low` never asserted produces no recall when `sup_ok` returns. The working contents are kept.
- R8: A one-cycle `sw_recall` while idle with `sup_ok`=1 performs the same copy from shadow to working array. `busy` is high for `RESTORE_CYC` cycles.
- R9: A read presented while `busy`=1 is dropped, and `host_rvalid` stays 0.
- R10: Every store or recall ends with `done`=1 for exactly one cycle, in the cycle where `busy` falls. At that point `dirty` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_ok | input | 1 | Supply above switch threshold |
| sup_low | input | 1 | Supply below reset threshold |
| sw_recall | input | 1 | Software recall request (pulse) |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data strobe, one cycle after an accepted read |
| host_wrej | output | 1 | One-cycle pulse for a dropped write |
| busy | output | 1 | Store or recall in progress |
| done | output | 1 | One-cycle transfer completion pulse |
| dirty | output | 1 | A write was accepted since the last completed transfer |

## Verification
The bench checks that the shadow really holds the snapshot. After a store it writes new data, issues a software recall, and expects the old bytes back. A design that never copied into the shadow, or that copied from the wrong index, returns the new or garbled bytes.

A clean supply drop and a shallow dip are each run separately. These catch a design that stores without a prior write, or that recalls after a brownout that never crossed the reset level.

Writes are attempted while the supply is low and during a recall, and a read is attempted while busy. A design that lets these through either corrupts a byte the bench reads back later, or emits an unexpected read strobe.

Busy lengths, the low grace window and the timing of the done pulse are all counted exactly. An off-by-one in the pad counter is therefore reported.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GRACE  = 2'd1,
        ST_STORE  = 2'd2,
        ST_RECALL = 2'd3
    } nvs_state_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/nvs_bank.sv
module nvs_bank #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    // Contents are deliberately not reset.
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int GRACE_CYC   = 3,
    parameter int STORE_CYC   = 40,
    parameter int RESTORE_CYC = 24,
    localparam int AW         = $clog2(DEPTH),
    localparam int MAXC       = max_of(max_of(GRACE_CYC, DEPTH),
                                       max_of(STORE_CYC, RESTORE_CYC)),
    localparam int CW         = $clog2(MAXC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sup_ok,
    input  logic          sup_low,
    input  logic          sw_recall,
    input  logic          wr_try,
    input  logic          rd_try,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic          store_we,
    output logic          recall_we,
    output logic          snap_rd,
    output logic [AW-1:0] copy_idx,
    output logic          busy,
    output logic          done,
    output logic          dirty,
    output logic          wrej,
    output logic          rvalid
);
    localparam logic [CW-1:0] GRACE_LAST   = CW'(GRACE_CYC - 1);
    localparam logic [CW-1:0] STORE_LAST   = CW'(STORE_CYC - 1);
    localparam logic [CW-1:0] RESTORE_LAST = CW'(RESTORE_CYC - 1);
    localparam logic [CW-1:0] COPY_END     = CW'(DEPTH);

    typedef struct packed {
        nvs_state_e    st;
        logic [CW-1:0] cnt;
        logic          dirty;
        logic          pend;
        logic          sup_prev;
        logic          done;
        logic          wrej;
        logic          rvalid;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic fell_w, launch_w, copy_on_w;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.done   = 1'b0;
        ctl_d.sup_prev = sup_ok;

        fell_w    = ctl_q.sup_prev & ~sup_ok;
        launch_w  = (ctl_q.st == ST_IDLE) & sup_ok & (ctl_q.pend | sw_recall);
        copy_on_w = ctl_q.cnt < COPY_END;

        wr_ok     = wr_try & sup_ok & (ctl_q.st == ST_IDLE) & ~launch_w;
        rd_ok     = rd_try & ((ctl_q.st == ST_IDLE) | (ctl_q.st == ST_GRACE));
        store_we  = (ctl_q.st == ST_STORE) & copy_on_w;
        recall_we = (ctl_q.st == ST_RECALL) & copy_on_w;
        snap_rd   = (ctl_q.st == ST_STORE);

        ctl_d.rvalid = rd_ok;
        ctl_d.wrej   = wr_try & ~wr_ok;
        ctl_d.pend   = (ctl_q.pend & ~launch_w) | sup_low;
        if (wr_ok) begin
            ctl_d.dirty = 1'b1;
        end

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (fell_w && ctl_q.dirty) begin
                    ctl_d.st  = ST_GRACE;
                    ctl_d.cnt = '0;
                end else if (launch_w) begin
                    ctl_d.st  = ST_RECALL;
                    ctl_d.cnt = '0;
                end
            end
            ST_GRACE: begin
                if (ctl_q.cnt == GRACE_LAST) begin
                    ctl_d.st  = ST_STORE;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_STORE: begin
                if (ctl_q.cnt == STORE_LAST) begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.cnt   = '0;
                    ctl_d.done  = 1'b1;
                    ctl_d.dirty = 1'b0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_RECALL: begin
                if (ctl_q.cnt == RESTORE_LAST) begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.cnt   = '0;
                    ctl_d.done  = 1'b1;
                    ctl_d.dirty = 1'b0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st       <= ST_IDLE;
            ctl_q.cnt      <= '0;
            ctl_q.dirty    <= 1'b0;
            ctl_q.pend     <= 1'b1;
            ctl_q.sup_prev <= 1'b0;
            ctl_q.done     <= 1'b0;
            ctl_q.wrej     <= 1'b0;
            ctl_q.rvalid   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign copy_idx = ctl_q.cnt[AW-1:0];
    assign busy     = (ctl_q.st == ST_STORE) | (ctl_q.st == ST_RECALL);
    assign done     = ctl_q.done;
    assign dirty    = ctl_q.dirty;
    assign wrej     = ctl_q.wrej;
    assign rvalid   = ctl_q.rvalid;
endmodule

// File: rtl/nvshadow_ctrl.sv
module nvshadow_ctrl #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int GRACE_CYC   = 3,
    parameter int STORE_CYC   = 40,
    parameter int RESTORE_CYC = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sup_ok,
    input  logic              sup_low,
    input  logic              sw_recall,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              host_wrej,
    output logic              busy,
    output logic              done,
    output logic              dirty
);
    localparam int DEPTH = 1 << ADDR_W;

    logic              wr_ok, rd_ok, store_we, recall_we, snap_rd;
    logic [ADDR_W-1:0] copy_idx;
    logic [DATA_W-1:0] wk_rdata, sh_rdata, wk_wdata;
    logic [ADDR_W-1:0] wk_waddr, wk_raddr;
    logic              wk_we;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    nvs_seq #(
        .DEPTH      (DEPTH),
        .GRACE_CYC  (GRACE_CYC),
        .STORE_CYC  (STORE_CYC),
        .RESTORE_CYC(RESTORE_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sup_ok   (sup_ok),
        .sup_low  (sup_low),
        .sw_recall(sw_recall),
        .wr_try   (host_req & host_we),
        .rd_try   (host_req & ~host_we),
        .wr_ok    (wr_ok),
        .rd_ok    (rd_ok),
        .store_we (store_we),
        .recall_we(recall_we),
        .snap_rd  (snap_rd),
        .copy_idx (copy_idx),
        .busy     (busy),
        .done     (done),
        .dirty    (dirty),
        .wrej     (host_wrej),
        .rvalid   (host_rvalid)
    );

    always_comb begin
        wk_we    = wr_ok | recall_we;
        wk_waddr = recall_we ? copy_idx : host_addr;
        wk_wdata = recall_we ? sh_rdata : host_wdata;
        wk_raddr = snap_rd ? copy_idx : host_addr;
        rdata_d  = rd_ok ? wk_rdata : rdata_q;
    end

    nvs_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_work (
        .clk  (clk),
        .we   (wk_we),
        .waddr(wk_waddr),
        .wdata(wk_wdata),
        .raddr(wk_raddr),
        .rdata(wk_rdata)
    );

    nvs_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_shadow (
        .clk  (clk),
        .we   (store_we),
        .waddr(copy_idx),
        .wdata(wk_rdata),
        .raddr(copy_idx),
        .rdata(sh_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign host_rdata = rdata_q;
endmodule

// File: rtl/nvs_chk.sv
module nvs_chk #(
    parameter int STORE_CYC   = 40,
    parameter int RESTORE_CYC = 24
) (
    input logic clk,
    input logic rst_n,
    input logic sup_ok,
    input logic host_req,
    input logic host_we,
    input logic busy,
    input logic done,
    input logic dirty,
    input logic host_rvalid,
    input logic host_wrej
);
    localparam int RUN_MAX = (STORE_CYC > RESTORE_CYC) ? STORE_CYC : RESTORE_CYC;

    int unsigned run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (busy) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    // R10
    done_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dirty);
    // R3
    wrej_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wrej |-> $past(host_req && host_we));
    // R3
    wrej_lowsup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_we && (!sup_ok || busy)) |=> host_wrej);
    // R9
    rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(host_req && !host_we && !busy));
    // R2
    dirty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dirty) |-> $past(host_req && host_we && sup_ok && !busy));
    // R4
    busy_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_MAX);
endmodule

bind nvshadow_ctrl nvs_chk #(
    .STORE_CYC  (STORE_CYC),
    .RESTORE_CYC(RESTORE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sup_ok     (sup_ok),
    .host_req   (host_req),
    .host_we    (host_we),
    .busy       (busy),
    .done       (done),
    .dirty      (dirty),
    .host_rvalid(host_rvalid),
    .host_wrej  (host_wrej)
);

// File: tb/nvshadow_ctrl_test.sv
module nvshadow_ctrl_test;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int G  = 3;
    localparam int S  = 40;
    localparam int RC = 24;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sup_ok = 1'b0, sup_low = 1'b0, sw_recall = 1'b0;
    logic          host_req = 1'b0, host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_rvalid, host_wrej, busy, done, dirty;

    int n_chk = 0;
    int n_err = 0;
    logic [DW-1:0] ref_work [DEPTH];
    logic [DW-1:0] expq [$];

    always #10 clk = ~clk;

    nvshadow_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .GRACE_CYC(G), .STORE_CYC(S), .RESTORE_CYC(RC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sup_ok(sup_ok), .sup_low(sup_low),
        .sw_recall(sw_recall), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .host_wrej(host_wrej), .busy(busy),
        .done(done), .dirty(dirty)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data as strobes appear
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R9 unexpected read strobe", 1, 0);
            end else begin
                logic [DW-1:0] e;
                e = expq.pop_front();
                chk(host_rdata == e, "R2 read data", int'(host_rdata), int'(e));
            end
        end
    end

    task automatic wr(input int a, input int d, input bit exp_rej, input string tag);
        host_req = 1'b1; host_we = 1'b1;
        host_addr = AW'(a); host_wdata = DW'(d);
        @(negedge clk);
        chk(host_wrej == exp_rej, tag, int'(host_wrej), int'(exp_rej));
        if (!exp_rej) ref_work[a] = DW'(d);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic rd(input int a, input bit expect_data);
        if (expect_data) expq.push_back(ref_work[a]);
        host_req = 1'b1; host_we = 1'b0; host_addr = AW'(a);
        @(negedge clk);
        host_req = 1'b0;
    endtask

    task automatic rd_all();
        for (int a = 0; a < DEPTH; a++) rd(a, 1'b1);
        @(negedge clk);
    endtask

    task automatic wait_busy(input int exp_low, input int exp_high, input int pre_high,
                             input string tag);
        int lo = 0;
        int hi = pre_high;
        bit fin = 1'b0;
        while (!fin && lo + hi < 1000) begin
            @(negedge clk);
            if (busy) hi++;
            else if (hi > 0) fin = 1'b1;
            else lo++;
        end
        chk(lo == exp_low, {tag, " idle cycles before busy"}, lo, exp_low);
        chk(hi == exp_high, {tag, " busy length"}, hi, exp_high);
        chk(done == 1'b1, "R10 done with busy fall", int'(done), 1);
        chk(dirty == 1'b0, "R10 dirty clear at end", int'(dirty), 0);
    endtask

    task automatic quiet(input int cycles, input string tag);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (busy || done) seen++;
        end
        chk(seen == 0, tag, seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({busy, done, dirty, host_rvalid, host_wrej} == 5'b0, "R1 reset outputs",
            int'({busy, done, dirty, host_rvalid, host_wrej}), 0);
        quiet(3, "R1 no transfer while supply low");

        // R1 / R6: pending recall from reset launches on supply up
        sup_ok = 1'b1;
        wait_busy(0, RC, 0, "R1 power-up recall");

        // R2 fill working array
        for (int a = 0; a < DEPTH; a++) wr(a, a * 17 + 3, 1'b0, "R2 write accepted");
        chk(dirty == 1'b1, "R2 dirty set", int'(dirty), 1);
        rd_all();

        // R4 power-fail store with dirty set
        sup_ok = 1'b0;
        wait_busy(G, S, 0, "R4 store");

        // R3 write while supply low is rejected
        wr(0, 8'hEE, 1'b1, "R3 reject on low supply");
        chk(dirty == 1'b0, "R3 dirty unchanged", int'(dirty), 0);

        // R7 shallow dip: no recall on return
        sup_ok = 1'b1;
        quiet(20, "R7 no recall after brownout");
        rd_all();

        // R5 clean drop: no store
        sup_ok = 1'b0;
        quiet(S + G + 10, "R5 no store when clean");
        sup_ok = 1'b1;
        quiet(5, "R7 no recall after clean dip");

        // R8 software recall restores the shadow snapshot
        wr(2, 8'h5A, 1'b0, "R2 write accepted");
        wr(9, 8'hC3, 1'b0, "R2 write accepted");
        for (int a = 0; a < DEPTH; a++) ref_work[a] = DW'(a * 17 + 3);
        sw_recall = 1'b1;
        @(negedge clk);
        sw_recall = 1'b0;
        chk(busy == 1'b1, "R8 recall started", int'(busy), 1);
        wr(2, 8'h55, 1'b1, "R3 reject while busy");
        rd(2, 1'b0); // R9 dropped read
        wait_busy(0, RC, 3, "R8 software recall");
        rd_all();

        // R6 supply dip below reset level latches and launches a recall
        wr(4, 8'h99, 1'b0, "R2 write accepted");
        chk(dirty == 1'b1, "R2 dirty set", int'(dirty), 1);
        ref_work[4] = DW'(4 * 17 + 3);
        sup_low = 1'b1;
        @(negedge clk);
        sup_low = 1'b0;
        chk(busy == 1'b0, "R6 latch cycle", int'(busy), 0);
        wait_busy(0, RC, 0, "R6 reset-level recall");
        rd_all();

        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R2 all reads answered", expq.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule